// File: doc/BRIEF.md
# Maskable Interrupt Vector Arbiter with Software Promotion

This block looks at every pending interrupt request and reports the 16-bit vector address of the request that should be served next. The non-maskable request always wins when it is unmasked. Below it is a bank of maskable sources. Each maskable source has a fixed vector address at an even location, and the addresses count down from 0xFFF2. When no source is promoted, a higher vector address means a higher priority.

Software can promote one maskable source above all the others. It does this by writing the low byte of that source's vector address into an 8-bit promotion register. Only bits 7:1 are stored, and bit 0 always reads back as zero. A write is accepted only while the CPU maskable-interrupt mask bit is set. If the stored byte does not name an implemented maskable vector, the source at 0xFFF2 is treated as the top maskable source.

The wake-up output is purely combinational, so it works while the block clock is stopped in a low-power mode. The arbitration result is combinational as well. The only state in the block is the promotion register.

Top module: `vec_arbiter`

## Requirements
- R1: After reset the promotion register reads 0xF2.
- R2: While `i_mask` is 1, a write through `wr_en` stores `wr_data[7:1]`. The new value is visible on `rd_data` after the next clock edge, and `rd_data[0]` is always 0.
- R3: While `i_mask` is 0, a write has no effect on the promotion register.
- R4: Maskable source k (bit k of `irq_req`) has vector 0xFFF2 − 2·k. Without a valid promotion, the lowest-numbered pending source wins.
- R5: When the promotion value equals the low byte of an implemented source's vector and that source is pending, it wins over all other maskable requests.
- R6: A promotion value above 0xF2, or below the lowest implemented vector, is invalid. Arbitration then uses the fixed order of R4, with the 0xFFF2 source on top.
- R7: With `x_mask` at 0, a non-maskable request outranks all maskable ones and yields vector 0xFFF4. With `x_mask` at 1, that request is ignored.
- R8: With `i_mask` at 1, maskable requests are ignored. `int_pending` is 1 exactly when some unmasked request is active.
- R9: `wake` follows an unmasked request combinationally, with no clock edge needed.
- R10: The vector output's upper byte is always 0xFF. With nothing pending, the output is 0xFFF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Maskable request lines, bit 0 = vector 0xFFF2 |
| xirq_req | input | 1 | Non-maskable request |
| i_mask | input | 1 | CPU mask for maskable requests (1 = masked) |
| x_mask | input | 1 | CPU mask for the non-maskable request (1 = masked) |
| wr_en | input | 1 | Promotion register write strobe |
| wr_data | input | 8 | Promotion register write data |
| rd_data | output | 8 | Promotion register contents |
| vec_addr | output | 16 | Vector address of the winning request |
| int_pending | output | 1 | An unmasked request is active |
| wake | output | 1 | Asynchronous wake-up indication |

## Verification
The hardest case to reach is a promoted source winning while higher-ranked fixed sources are pending at the same time. Reaching it takes a gated write with `i_mask` high, followed by dropping the mask with several requests active. The bench also writes invalid bytes on both sides of the implemented range and confirms that the fixed order comes back. For the wake-up path, the bench stops the clock and changes requests and masks, checking `wake` with no edge at all.

// File: rtl/vecarb_pkg.sv
package vecarb_pkg;
    localparam logic [7:0] TOP_LOW  = 8'hF2;
    localparam logic [7:0] XIRQ_LOW = 8'hF4;
    localparam logic [7:0] VEC_HIGH = 8'hFF;

    function automatic logic [7:0] src_low(input int idx);
        return TOP_LOW - 8'(2 * idx);
    endfunction
endpackage

// File: rtl/promo_reg.sv
module promo_reg
    import vecarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       i_mask,
    input  logic [7:0] wr_data,
    output logic [7:0] value
);
    logic [6:0] stored_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stored_q <= TOP_LOW[7:1];
        else if (wr_en && i_mask)
            stored_q <= wr_data[7:1];
    end

    assign value = {stored_q, 1'b0};
endmodule

// File: rtl/promo_decode.sv
module promo_decode
    import vecarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [7:0]      value,
    output logic            valid,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (value == src_low(i)) begin
                valid = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_select.sv
module prio_select
    import vecarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               xirq_req,
    input  logic               i_mask,
    input  logic               x_mask,
    input  logic               promo_valid,
    input  logic [IDXW-1:0]    promo_idx,
    output logic [7:0]         sel_low,
    output logic               pending
);
    logic [NUM_SRC-1:0] live;
    logic               x_live;
    logic               fixed_hit;
    logic [IDXW-1:0]    fixed_idx;

    assign live   = i_mask ? '0 : irq_req;
    assign x_live = xirq_req && !x_mask;

    always_comb begin
        fixed_hit = 1'b0;
        fixed_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                fixed_hit = 1'b1;
                fixed_idx = IDXW'(i);
            end
        end
    end

    always_comb begin
        if (x_live)
            sel_low = XIRQ_LOW;
        else if (promo_valid && live[promo_idx])
            sel_low = src_low(int'(promo_idx));
        else if (fixed_hit)
            sel_low = src_low(int'(fixed_idx));
        else
            sel_low = TOP_LOW;
    end

    assign pending = x_live || fixed_hit;
endmodule

// File: rtl/vec_arbiter.sv
module vec_arbiter
    import vecarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               xirq_req,
    input  logic               i_mask,
    input  logic               x_mask,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic [15:0]        vec_addr,
    output logic               int_pending,
    output logic               wake
);
    logic [7:0]      promo_value;
    logic            promo_valid;
    logic [IDXW-1:0] promo_idx;
    logic [7:0]      sel_low;

    promo_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .i_mask  (i_mask),
        .wr_data (wr_data),
        .value   (promo_value)
    );

    promo_decode #(.NUM_SRC(NUM_SRC)) u_dec (
        .value (promo_value),
        .valid (promo_valid),
        .idx   (promo_idx)
    );

    prio_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .irq_req     (irq_req),
        .xirq_req    (xirq_req),
        .i_mask      (i_mask),
        .x_mask      (x_mask),
        .promo_valid (promo_valid),
        .promo_idx   (promo_idx),
        .sel_low     (sel_low),
        .pending     (int_pending)
    );

    // Clock-free path for low-power wake-up
    assign wake = (xirq_req && !x_mask) || (!i_mask && (|irq_req));

    assign rd_data  = promo_value;
    assign vec_addr = {VEC_HIGH, sel_low};
endmodule

module vec_arbiter_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               xirq_req,
    input logic               i_mask,
    input logic               x_mask,
    input logic               wr_en,
    input logic [7:0]         wr_data,
    input logic [7:0]         rd_data,
    input logic [15:0]        vec_addr,
    input logic               int_pending,
    input logic               wake
);
    // R2
    lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

    // R2
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && i_mask) |=> (rd_data[7:1] == $past(wr_data[7:1])));

    // R3
    write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !i_mask) |=> $stable(rd_data));

    // R7
    xirq_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xirq_req && !x_mask) |-> (vec_addr == 16'hFFF4));

    // R8
    masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_mask && (x_mask || !xirq_req)) |-> !int_pending);

    // R9
    wake_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake == int_pending);

    // R10
    upper_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_addr[15:8] == 8'hFF);
endmodule

bind vec_arbiter vec_arbiter_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/test_vec_arbiter.sv
module test_vec_arbiter;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         clk_run = 1'b1;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic         xirq_req = 1'b0;
    logic         i_mask = 1'b1;
    logic         x_mask = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = '0;
    logic [7:0]   rd_data;
    logic [15:0]  vec_addr;
    logic         int_pending;
    logic         wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 if (clk_run) clk = ~clk;

    vec_arbiter #(.NUM_SRC(N)) i_vec_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .xirq_req(xirq_req),
        .i_mask(i_mask), .x_mask(x_mask), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .vec_addr(vec_addr), .int_pending(int_pending),
        .wake(wake)
    );

    function automatic logic [15:0] vec_of(int k);
        return 16'hFFF2 - 16'(2 * k);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_promo(logic [7:0] d, logic m);
        @(negedge clk);
        i_mask  = m;
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check("R1", {8'h00, rd_data}, 16'h00F2);
        check("R10", vec_addr, 16'hFFF2);
        check("R8", {15'd0, int_pending}, 16'd0);
    endtask

    task automatic t_write_gate;
        write_promo(8'hEB, 1'b1);
        check("R2", {8'h00, rd_data}, 16'h00EA);
        write_promo(8'hE4, 1'b0);
        check("R3", {8'h00, rd_data}, 16'h00EA);
        write_promo(8'hF2, 1'b1);
        check("R2", {8'h00, rd_data}, 16'h00F2);
    endtask

    task automatic t_fixed_order;
        @(negedge clk);
        i_mask  = 1'b0;
        irq_req = 8'b1010_1000;
        #1;
        check("R4", vec_addr, vec_of(3));
        check("R8", {15'd0, int_pending}, 16'd1);
        irq_req = 8'b1000_0000;
        #1;
        check("R4", vec_addr, vec_of(7));
        irq_req = 8'b0000_0001;
        #1;
        check("R4", vec_addr, vec_of(0));
        i_mask = 1'b1;
        #1;
        check("R8", {15'd0, int_pending}, 16'd0);
        check("R10", vec_addr, 16'hFFF2);
        irq_req = '0;
    endtask

    task automatic t_promotion;
        write_promo(8'hE8, 1'b1);
        @(negedge clk);
        i_mask  = 1'b0;
        irq_req = 8'b0010_0011;
        #1;
        check("R5", vec_addr, vec_of(5));
        irq_req = 8'b0000_0011;
        #1;
        check("R5", vec_addr, vec_of(0));
        write_promo(8'hE4, 1'b1);
        @(negedge clk);
        i_mask  = 1'b0;
        irq_req = 8'b1000_0001;
        #1;
        check("R5", vec_addr, vec_of(7));
        i_mask  = 1'b1;
        irq_req = '0;
    endtask

    task automatic t_invalid;
        write_promo(8'hF6, 1'b1);
        @(negedge clk);
        i_mask  = 1'b0;
        irq_req = 8'b0100_1001;
        #1;
        check("R6", vec_addr, vec_of(0));
        irq_req = 8'b0100_1000;
        #1;
        check("R6", vec_addr, vec_of(3));
        write_promo(8'hE2, 1'b1);
        @(negedge clk);
        i_mask  = 1'b0;
        irq_req = 8'b1000_0100;
        #1;
        check("R6", vec_addr, vec_of(2));
        i_mask  = 1'b1;
        irq_req = '0;
    endtask

    task automatic t_xirq;
        @(negedge clk);
        i_mask   = 1'b0;
        irq_req  = 8'b0000_0001;
        xirq_req = 1'b1;
        x_mask   = 1'b0;
        #1;
        check("R7", vec_addr, 16'hFFF4);
        x_mask = 1'b1;
        #1;
        check("R7", vec_addr, vec_of(0));
        i_mask = 1'b1;
        #1;
        check("R7", {15'd0, int_pending}, 16'd0);
        xirq_req = 1'b0;
        irq_req  = '0;
    endtask

    task automatic t_wake;
        @(negedge clk);
        clk_run = 1'b0;
        #10;
        check("R9", {15'd0, wake}, 16'd0);
        irq_req = 8'b0001_0000;
        #1;
        check("R9", {15'd0, wake}, 16'd0);
        i_mask = 1'b0;
        #1;
        check("R9", {15'd0, wake}, 16'd1);
        i_mask   = 1'b1;
        irq_req  = '0;
        xirq_req = 1'b1;
        x_mask   = 1'b0;
        #1;
        check("R9", {15'd0, wake}, 16'd1);
        xirq_req = 1'b0;
        x_mask   = 1'b1;
        #1;
        check("R9", {15'd0, wake}, 16'd0);
        clk_run = 1'b1;
        #5;
    endtask

    initial begin
        #12;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_write_gate();
        t_fixed_order();
        t_promotion();
        t_invalid();
        t_xirq();
        t_wake();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #500000;
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule